// File: doc/BRIEF.md
# Privileged Instruction Trap Decision Logic

This block settles what happens when a core issues one of four privileged instructions: wait-for-interrupt, the supervisor address-translation fence, the hypervisor fence for guest virtual addresses, and the hypervisor fence for guest-physical addresses. The core presents the instruction kind together with its current privilege, the virtualization flag, whether the supervisor extension is implemented, and four interception bits. These are timeout-wait and trap-virtual-memory, set by the machine level, plus their virtual counterparts, set by the hypervisor.

For each request, one clock later the block produces exactly one outcome with a one-cycle valid strobe. The outcome is one of: raise illegal instruction, raise a virtual-instruction fault, halt (wait only), or perform a TLB flush (fences only). An exception cause code comes with it. The block decides only. The TLB itself and interrupt wakeup belong elsewhere.

Top module: `priv_trap_decide`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `outValid`, all four outcome flags and `causeCode` are zero.
- R2: A request sampled at a rising edge with `reqValid` high makes `outValid` high for exactly the following cycle. Without a request, `outValid` is low.
- R3: When `outValid` is high, exactly one of `raiseIllegal`, `raiseVirtual`, `doHalt`, `doFlush` is high. When it is low, all four are low. `doHalt` only follows a wait, and `doFlush` only follows a fence.
- R4: `causeCode` is 2 with `raiseIllegal`, 22 with `raiseVirtual`, and 0 otherwise.
- R5: Wait (kind 0) raises illegal instruction when timeout-wait is set and the privilege is supervisor, or user with no supervisor extension. It also raises illegal instruction at user privilege with the supervisor extension present and virtualization off.
- R6: A wait not covered by R5 raises a virtual-instruction fault under virtualization when the privilege is user, or when it is supervisor with virtual timeout-wait set. Any other wait halts.
- R7: Supervisor fence (kind 1) without virtualization raises illegal instruction at user privilege, or at supervisor privilege with trap-virtual-memory set. Under virtualization it raises a virtual-instruction fault at user privilege or with virtual trap-virtual-memory set. Any other supervisor fence flushes.
- R8: Hypervisor guest-virtual fence (kind 2) under virtualization always raises a virtual-instruction fault. Otherwise it flushes at machine privilege or at supervisor privilege, and raises illegal instruction at any other privilege.
- R9: Hypervisor guest-physical fence (kind 3) raises illegal instruction at supervisor privilege with virtualization off and trap-virtual-memory set. Otherwise it follows R8.
- R10: The privilege encoding is 0 user, 1 supervisor, 3 machine. Code 2 counts as none of these three in every rule above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqKind | input | 2 | 0 wait, 1 supervisor fence, 2 guest-virtual fence, 3 guest-physical fence |
| curPriv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| virtOn | input | 1 | Virtualization active |
| sExtPresent | input | 1 | Supervisor extension implemented |
| waitTrapBit | input | 1 | Timeout-wait interception (machine level) |
| vmTrapBit | input | 1 | Trap-virtual-memory interception (machine level) |
| vWaitTrapBit | input | 1 | Virtual timeout-wait interception |
| vVmTrapBit | input | 1 | Virtual trap-virtual-memory interception |
| outValid | output | 1 | One-cycle result strobe |
| raiseIllegal | output | 1 | Outcome: illegal instruction |
| raiseVirtual | output | 1 | Outcome: virtual-instruction fault |
| doHalt | output | 1 | Outcome: halt until interrupt |
| doFlush | output | 1 | Outcome: perform TLB flush |
| causeCode | output | 5 | Exception cause for the outcome |

## Verification
Every result is due exactly one rising edge after the edge that samples the request, because the decision is combinational and only the output register lies in between. The bench drives each request on a falling edge. It reads the outcome on the next falling edge, half a cycle after the registering edge, and then idles one cycle to confirm that the strobe falls. The sweep covers every kind, privilege code and combination of the six flags, 1024 vectors in all.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;
  localparam int PRIV_W  = 2;
  localparam int KIND_W  = 2;
  localparam int CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = CAUSE_W'(2);
  localparam logic [CAUSE_W-1:0] CAUSE_VIRTUAL = CAUSE_W'(22);

  localparam logic [PRIV_W-1:0] PRIV_USER    = 2'd0;
  localparam logic [PRIV_W-1:0] PRIV_SUPER   = 2'd1;
  localparam logic [PRIV_W-1:0] PRIV_MACHINE = 2'd3;

  typedef enum logic [KIND_W-1:0] {
    KIND_WAIT   = 2'd0,
    KIND_SFENCE = 2'd1,
    KIND_HVVMA  = 2'd2,
    KIND_HGVMA  = 2'd3
  } instrKind_t;

  typedef struct packed {
    logic fire;
    logic illegal;
    logic virtFault;
    logic halt;
    logic flush;
  } trapStrobes_t;
endpackage

// File: rtl/priv_trap_ctrl.sv
module priv_trap_ctrl
  import priv_trap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [KIND_W-1:0] reqKind,
  input  logic [PRIV_W-1:0] curPriv,
  input  logic              virtOn,
  input  logic              sExtPresent,
  input  logic              waitTrapBit,
  input  logic              vmTrapBit,
  input  logic              vWaitTrapBit,
  input  logic              vVmTrapBit,
  output trapStrobes_t      strobes
);
  logic isUser, isSuper, isMachine;
  logic waitIll, waitVirt;
  logic sfIll, sfVirt;
  logic hvIll, hvVirt;
  logic hgPreIll;
  logic pickIll, pickVirt;

  assign isUser    = (curPriv == PRIV_USER);
  assign isSuper   = (curPriv == PRIV_SUPER);
  assign isMachine = (curPriv == PRIV_MACHINE);

  always_comb begin
    // wait: machine-level interception checked before the hypervisor one
    waitIll  = ((isSuper || (!sExtPresent && isUser)) && waitTrapBit) ||
               (sExtPresent && isUser && !virtOn);
    waitVirt = virtOn && (isUser || (isSuper && vWaitTrapBit));
    // supervisor fence
    sfIll    = !virtOn && (isUser || (isSuper && vmTrapBit));
    sfVirt   = virtOn && (isUser || vVmTrapBit);
    // hypervisor fences
    hvVirt   = virtOn;
    hvIll    = !(isMachine || (isSuper && !virtOn));
    hgPreIll = isSuper && !virtOn && vmTrapBit;

    pickIll  = 1'b0;
    pickVirt = 1'b0;
    unique case (instrKind_t'(reqKind))
      KIND_WAIT: begin
        pickIll  = waitIll;
        pickVirt = !waitIll && waitVirt;
      end
      KIND_SFENCE: begin
        pickIll  = sfIll;
        pickVirt = !sfIll && sfVirt;
      end
      KIND_HVVMA: begin
        pickVirt = hvVirt;
        pickIll  = !hvVirt && hvIll;
      end
      KIND_HGVMA: begin
        pickIll  = hgPreIll || (!hvVirt && hvIll);
        pickVirt = !hgPreIll && hvVirt;
      end
      default: ;
    endcase

    strobes.fire      = reqValid;
    strobes.illegal   = reqValid && pickIll;
    strobes.virtFault = reqValid && pickVirt;
    strobes.halt      = reqValid && !pickIll && !pickVirt &&
                        (reqKind == KIND_WAIT);
    strobes.flush     = reqValid && !pickIll && !pickVirt &&
                        (reqKind != KIND_WAIT);
  end

  // R8: a guest-virtual fence under virtualization never escapes the fault
  assert_hvvma_virt_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == KIND_HVVMA && virtOn) |-> strobes.virtFault);

  // R9: machine-level memory trap wins over everything for guest-physical fence
  assert_hgvma_pre_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == KIND_HGVMA && isSuper && !virtOn && vmTrapBit)
      |-> (strobes.illegal && !strobes.flush));

  // R6: machine privilege wait without virtualization always halts
  assert_wait_machine_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == KIND_WAIT && isMachine && !virtOn) |-> strobes.halt);
endmodule

// File: rtl/priv_trap_datapath.sv
module priv_trap_datapath
  import priv_trap_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  trapStrobes_t       strobes,
  output logic               outValid,
  output logic               raiseIllegal,
  output logic               raiseVirtual,
  output logic               doHalt,
  output logic               doFlush,
  output logic [CAUSE_W-1:0] causeCode
);
  logic [CAUSE_W-1:0] nextCause;

  always_comb begin
    nextCause = '0;
    if (strobes.illegal)        nextCause = CAUSE_ILLEGAL;
    else if (strobes.virtFault) nextCause = CAUSE_VIRTUAL;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid     <= 1'b0;
      raiseIllegal <= 1'b0;
      raiseVirtual <= 1'b0;
      doHalt       <= 1'b0;
      doFlush      <= 1'b0;
      causeCode    <= '0;
    end else begin
      outValid     <= strobes.fire;
      raiseIllegal <= strobes.illegal;
      raiseVirtual <= strobes.virtFault;
      doHalt       <= strobes.halt;
      doFlush      <= strobes.flush;
      causeCode    <= nextCause;
    end
  end

  assert_one_outcome_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $onehot({raiseIllegal, raiseVirtual, doHalt, doFlush}));

  assert_quiet_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ({raiseIllegal, raiseVirtual, doHalt, doFlush} == 4'b0000));

  assert_cause_match_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && raiseVirtual) |-> (causeCode == CAUSE_VIRTUAL));

  assert_cause_illegal_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && raiseIllegal) |-> (causeCode == CAUSE_ILLEGAL));

  assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fire |=> outValid);
endmodule

// File: rtl/priv_trap_decide.sv
module priv_trap_decide
  import priv_trap_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [KIND_W-1:0]  reqKind,
  input  logic [PRIV_W-1:0]  curPriv,
  input  logic               virtOn,
  input  logic               sExtPresent,
  input  logic               waitTrapBit,
  input  logic               vmTrapBit,
  input  logic               vWaitTrapBit,
  input  logic               vVmTrapBit,
  output logic               outValid,
  output logic               raiseIllegal,
  output logic               raiseVirtual,
  output logic               doHalt,
  output logic               doFlush,
  output logic [CAUSE_W-1:0] causeCode
);
  trapStrobes_t strobes;

  priv_trap_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .curPriv(curPriv), .virtOn(virtOn), .sExtPresent(sExtPresent),
    .waitTrapBit(waitTrapBit), .vmTrapBit(vmTrapBit),
    .vWaitTrapBit(vWaitTrapBit), .vVmTrapBit(vVmTrapBit),
    .strobes(strobes)
  );

  priv_trap_datapath uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .outValid(outValid), .raiseIllegal(raiseIllegal),
    .raiseVirtual(raiseVirtual), .doHalt(doHalt), .doFlush(doFlush),
    .causeCode(causeCode)
  );
endmodule

// File: tb/sim_priv_trap_decide.sv
module sim_priv_trap_decide;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [1:0] reqKind = 2'd0;
  logic [1:0] curPriv = 2'd0;
  logic       virtOn = 1'b0, sExtPresent = 1'b0;
  logic       waitTrapBit = 1'b0, vmTrapBit = 1'b0;
  logic       vWaitTrapBit = 1'b0, vVmTrapBit = 1'b0;
  logic       outValid, raiseIllegal, raiseVirtual, doHalt, doFlush;
  logic [4:0] causeCode;

  int vectors = 0;
  int misses = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  priv_trap_decide u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .curPriv(curPriv), .virtOn(virtOn), .sExtPresent(sExtPresent),
    .waitTrapBit(waitTrapBit), .vmTrapBit(vmTrapBit),
    .vWaitTrapBit(vWaitTrapBit), .vVmTrapBit(vVmTrapBit),
    .outValid(outValid), .raiseIllegal(raiseIllegal),
    .raiseVirtual(raiseVirtual), .doHalt(doHalt), .doFlush(doFlush),
    .causeCode(causeCode)
  );

  // outcome code: 0 illegal, 1 virtual fault, 2 halt, 3 flush
  function automatic int refOutcome(int k, int p, bit v, bit s, bit tw,
                                    bit tvm, bit vtw, bit vtvm);
    bit u = (p == 0);
    bit su = (p == 1);
    bit m = (p == 3);
    case (k)
      0: begin
        if (((su || (!s && u)) && tw) || (s && u && !v)) return 0;
        if (v && (u || (su && vtw))) return 1;
        return 2;
      end
      1: begin
        if (!v && (u || (su && tvm))) return 0;
        if (v && (u || vtvm)) return 1;
        return 3;
      end
      default: begin
        if (k == 3 && su && !v && tvm) return 0;
        if (v) return 1;
        if (m || (su && !v)) return 3;
        return 0;
      end
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] want);
    vectors++;
    if (got !== want) begin
      misses++;
      $display("FAIL %s: got %0d expected %0d (kind %0d priv %0d flags %b)",
               tag, got, want, reqKind, curPriv,
               {virtOn, sExtPresent, waitTrapBit, vmTrapBit, vWaitTrapBit, vVmTrapBit});
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    vectors++;
    misses++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", 32'(outValid), 0);
    check("R1 flags in reset", 32'({raiseIllegal, raiseVirtual, doHalt, doFlush}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", 32'(outValid), 0);
    check("R1 cause after reset", 32'(causeCode), 0);

    for (int k = 0; k < 4; k++) begin
      for (int p = 0; p < 4; p++) begin
        for (int f = 0; f < 64; f++) begin
          int want;
          string tag;
          reqKind = 2'(k); curPriv = 2'(p);
          {virtOn, sExtPresent, waitTrapBit, vmTrapBit, vWaitTrapBit, vVmTrapBit} = 6'(f);
          reqValid = 1'b1;
          want = refOutcome(k, p, virtOn, sExtPresent, waitTrapBit, vmTrapBit,
                            vWaitTrapBit, vVmTrapBit);
          case (k)
            0: tag = (want == 0) ? "R5 wait" : "R6 wait";
            1: tag = "R7 sfence";
            2: tag = "R8 hvvma";
            default: tag = "R9 hgvma";
          endcase
          if (p == 2) tag = {tag, " R10 reserved priv"};
          @(negedge clk);
          reqValid = 1'b0;
          check("R2 valid strobe", 32'(outValid), 1);
          check(tag, 32'({raiseIllegal, raiseVirtual, doHalt, doFlush}),
                32'(4'b1000 >> want));
          check("R4 cause", 32'(causeCode),
                (want == 0) ? 2 : (want == 1) ? 22 : 0);
          @(negedge clk);
          check("R2 strobe drops", 32'(outValid), 0);
          check("R3 idle flags", 32'({raiseIllegal, raiseVirtual, doHalt, doFlush}), 0);
        end
      end
    end

    // back-to-back requests: each result lands one cycle after its own request
    reqKind = 2'd2; curPriv = 2'd3;
    {virtOn, sExtPresent, waitTrapBit, vmTrapBit, vWaitTrapBit, vVmTrapBit} = 6'b0;
    reqValid = 1'b1;
    @(negedge clk);
    check("R2 back-to-back first", 32'({outValid, doFlush}), 32'(2'b11));
    virtOn = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check("R8 back-to-back second", 32'({outValid, raiseVirtual}), 32'(2'b11));
    check("R4 back-to-back cause", 32'(causeCode), 22);
    @(negedge clk);
    check("R2 trailing idle", 32'(outValid), 0);
    finish_run();
  end
endmodule